// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block sits on the host side of a 12-bit serial sampling converter. It produces the two control waveforms the converter needs, a conversion-start strobe and a serial bit clock. It shifts the returned data in one bit at a time and presents the finished sample as a parallel word with a one-cycle valid pulse. The bit clock comes from the system clock through an even divider. The strobe always falls on a system-clock tick while the bit clock is low, so the first bit-clock edge follows it by one full half-period.

Every conversion frame lasts a programmable number of bit-clock periods, with sixteen as the minimum. The strobe goes low to start a frame and stays low through the data phase. It rises a fixed number of periods before the frame ends, which gives the converter its acquisition window. When a frame is longer than sixteen periods, the strobe is still low at the thirteenth period. The converter then powers down until the strobe rises again, so slow sample rates draw little power without losing a conversion.

A start request received during a frame is held and launches the next frame directly after the current one. A request received while idle waits until the acquisition time has been met.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: During and directly after reset, `adc_conv_o` is 1, `adc_sclk_o` is 0, `result_valid_o` is 0 and `result_o` is 0.
- R2: `adc_conv_o` falls only while `adc_sclk_o` is low. The first rising edge of `adc_sclk_o` comes exactly DIV_HALF system cycles later. Each bit-clock period is a high half followed by a low half, and each half lasts DIV_HALF system cycles.
- R3: The frame length N is `periods_i` sampled at the falling edge of the strobe. A value below MIN_PERIODS (16) is replaced by 16. A frame contains exactly N rising bit-clock edges before the next strobe fall.
- R4: The strobe stays low for 2*(N-ACQ_PERIODS)+1 half-periods. It rises together with rising bit-clock edge N-ACQ_PERIODS+1 (ACQ_PERIODS = 4).
- R5: When N > 16, the strobe is still low at the 13th rising bit-clock edge of the frame, which sends the converter into power-down. When N = 16, the strobe is already high at that edge.
- R6: The converter presents a new bit after each falling bit-clock edge k (k = 1..12), with D11 first and D0 last. The block samples that bit on rising edge k+1, and `result_o` bit 11 holds the first bit received.
- R7: `result_valid_o` is a single-cycle pulse, one system cycle after the 12th bit is sampled. `result_o` changes only in the cycle where `result_valid_o` is high.
- R8: Before every strobe fall, including the first one after reset, the strobe has been high for at least 2*ACQ_PERIODS*DIV_HALF system cycles.
- R9: A start request received while a frame is running launches the next frame right after the frame's last period. The strobe is then high for exactly 2*ACQ_PERIODS*DIV_HALF system cycles.
- R10: While no start request is pending, the block is idle after a frame ends: the strobe stays high and the bit clock stays low with no edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, held until a frame starts |
| periods_i | input | CNT_W | Bit-clock periods per frame (minimum 16) |
| adc_dout_i | input | 1 | Serial data from the converter |
| adc_conv_o | output | 1 | Conversion-start strobe; a falling edge starts a frame |
| adc_sclk_o | output | 1 | Gated serial bit clock |
| result_o | output | DATA_W | Last completed sample, MSB first received |
| result_valid_o | output | 1 | One-cycle pulse when result_o updates |

## Verification
The hardest case to reach from the ports is the back-to-back launch. A request must arrive after the strobe has risen and before the frame's last half-period ends, so that the acquisition window is exactly met and not stretched by idle time. The stimulus waits until the strobe rises and issues the next request straight away. It mixes these requests with randomly spaced isolated frames and random lengths that cross the 16-period boundary. Power-down entry is checked by observing the strobe level at the 13th rising clock edge for frames of both lengths.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } seq_phase_e;
endpackage

// File: rtl/sadc_tick_gen.sv
module sadc_tick_gen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam logic [CW-1:0] TOP = CW'(DIV_HALF - 1);

   logic [CW-1:0] cnt_q;

   assign tick_o = (cnt_q == TOP);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
   import sadc_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int CNT_W       = 8,
   parameter int MIN_PERIODS = 16,
   parameter int ACQ_PERIODS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] periods_i,
   output logic             conv_o,
   output logic             sclk_o,
   output logic             cap_o,
   output logic             last_o
);
   localparam int HALF_W     = CNT_W + 2;
   localparam int ACQ_HALVES = 2 * ACQ_PERIODS;
   localparam int AW         = $clog2(ACQ_HALVES + 1);
   localparam logic [CNT_W-1:0]  MIN_N    = CNT_W'(MIN_PERIODS);
   localparam logic [CNT_W-1:0]  ACQ_N    = CNT_W'(ACQ_PERIODS);
   localparam logic [HALF_W-1:0] LAST_CAP = HALF_W'(2 * DATA_W);
   localparam logic [AW-1:0]     ACQ_FULL = AW'(ACQ_HALVES);

   seq_phase_e        phase_q;
   logic [HALF_W-1:0] half_q;
   logic [CNT_W-1:0]  nper_q;
   logic              pend_q;
   logic              conv_q;
   logic              sclk_q;
   logic [AW-1:0]     acq_q;

   logic [CNT_W-1:0]  nper_next;
   logic [HALF_W-1:0] end_half;
   logic [HALF_W-1:0] rise_half;
   logic [HALF_W-1:0] half_inc;
   logic              want;
   logic              frame_end;
   logic              ready;
   logic              launch;

   always_comb begin
      nper_next = (periods_i < MIN_N) ? MIN_N : periods_i;
      end_half  = {1'b0, nper_q, 1'b0};
      rise_half = {1'b0, nper_q - ACQ_N, 1'b1};
      half_inc  = half_q + 1'b1;
      want      = pend_q | start_i;
      frame_end = (phase_q == PH_RUN) && (half_q == end_half);
      ready     = (phase_q == PH_IDLE) ? (acq_q == ACQ_FULL) : frame_end;
      launch    = tick_i && want && ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         half_q  <= '0;
         nper_q  <= MIN_N;
         pend_q  <= 1'b0;
         conv_q  <= 1'b1;
         sclk_q  <= 1'b0;
         acq_q   <= '0;
      end else begin
         pend_q <= want && !launch;
         if (launch) begin
            phase_q <= PH_RUN;
            half_q  <= '0;
            nper_q  <= nper_next;
            conv_q  <= 1'b0;
            sclk_q  <= 1'b0;
         end else if (tick_i) begin
            if (phase_q == PH_IDLE) begin
               if (acq_q != ACQ_FULL) acq_q <= acq_q + 1'b1;
            end else if (frame_end) begin
               phase_q <= PH_IDLE;
               acq_q   <= ACQ_FULL;
               conv_q  <= 1'b1;
               sclk_q  <= 1'b0;
            end else begin
               half_q <= half_inc;
               sclk_q <= half_inc[0];
               if (half_inc == rise_half) conv_q <= 1'b1;
            end
         end
      end
   end

   assign conv_o = conv_q;
   assign sclk_o = sclk_q;
   assign cap_o  = tick_i && (phase_q == PH_RUN) && !half_q[0]
                   && (half_q != '0) && (half_q <= LAST_CAP);
   assign last_o = cap_o && (half_q == LAST_CAP);
endmodule

// File: rtl/sadc_shift_capture.sv
module sadc_shift_capture #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic              last_i,
   input  logic              din_i,
   output logic [DATA_W-1:0] result_o,
   output logic              valid_o
);
   logic [DATA_W-2:0] shift_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q  <= '0;
         result_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (cap_i) shift_q <= {shift_q[DATA_W-3:0], din_i};
         if (last_i) begin
            result_o <= {shift_q, din_i};
            valid_o  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl #(
   parameter int DATA_W      = 12,
   parameter int CNT_W       = 8,
   parameter int MIN_PERIODS = 16,
   parameter int ACQ_PERIODS = 4,
   parameter int DIV_HALF    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  periods_i,
   input  logic              adc_dout_i,
   output logic              adc_conv_o,
   output logic              adc_sclk_o,
   output logic [DATA_W-1:0] result_o,
   output logic              result_valid_o
);
   if (DIV_HALF < 1) begin : g_bad_div
      $error("DIV_HALF must be at least 1");
   end
   if (DATA_W < 4) begin : g_bad_width
      $error("DATA_W must be at least 4");
   end
   if (ACQ_PERIODS < 1) begin : g_bad_acq
      $error("ACQ_PERIODS must be at least 1");
   end
   if (MIN_PERIODS < DATA_W + ACQ_PERIODS) begin : g_bad_min
      $error("MIN_PERIODS too small for data plus acquisition");
   end
   if (MIN_PERIODS >= (1 << CNT_W)) begin : g_bad_cnt
      $error("CNT_W cannot hold MIN_PERIODS");
   end

   logic tick;
   logic cap;
   logic last;

   sadc_tick_gen #(
      .DIV_HALF(DIV_HALF)
   ) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_o(tick)
   );

   sadc_frame_seq #(
      .DATA_W     (DATA_W),
      .CNT_W      (CNT_W),
      .MIN_PERIODS(MIN_PERIODS),
      .ACQ_PERIODS(ACQ_PERIODS)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .start_i  (start_i),
      .periods_i(periods_i),
      .conv_o   (adc_conv_o),
      .sclk_o   (adc_sclk_o),
      .cap_o    (cap),
      .last_o   (last)
   );

   sadc_shift_capture #(
      .DATA_W(DATA_W)
   ) i_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap),
      .last_i  (last),
      .din_i   (adc_dout_i),
      .result_o(result_o),
      .valid_o (result_valid_o)
   );
endmodule

// File: rtl/sadc_frame_chk.sv
module sadc_frame_chk #(
   parameter int DATA_W      = 12,
   parameter int ACQ_PERIODS = 4,
   parameter int DIV_HALF    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adc_conv_o,
   input logic              adc_sclk_o,
   input logic [DATA_W-1:0] result_o,
   input logic              result_valid_o
);
   localparam int ACQ_CYC = 2 * ACQ_PERIODS * DIV_HALF;
   localparam int HW      = $clog2(ACQ_CYC + 1) + 1;
   localparam logic [HW-1:0] HI_SAT = HW'(ACQ_CYC);

   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                             hi_cnt <= '0;
      else if (!adc_conv_o)                   hi_cnt <= '0;
      else if (hi_cnt != HI_SAT)              hi_cnt <= hi_cnt + 1'b1;
   end

   // R2
   conv_fall_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_conv_o) |-> !adc_sclk_o);

   // R7
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid_o |=> !result_valid_o);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid_o |-> $stable(result_o));

   // R8
   acq_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_conv_o) |-> (hi_cnt >= HI_SAT));

   // R2
   sclk_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_conv_o) |-> $stable(adc_sclk_o) || $rose(adc_sclk_o));
endmodule

bind sadc_frame_ctrl sadc_frame_chk #(
   .DATA_W     (DATA_W),
   .ACQ_PERIODS(ACQ_PERIODS),
   .DIV_HALF   (DIV_HALF)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .adc_conv_o    (adc_conv_o),
   .adc_sclk_o    (adc_sclk_o),
   .result_o      (result_o),
   .result_valid_o(result_valid_o)
);

// File: tb/test_sadc_frame_ctrl.sv
`timescale 1ns/1ps
module test_sadc_frame_ctrl;
   localparam int DATA_W   = 12;
   localparam int CNT_W    = 8;
   localparam int MIN_N    = 16;
   localparam int ACQ      = 4;
   localparam int DIV      = 2;
   localparam int ACQ_CYC  = 2 * ACQ * DIV;
   localparam int WD_LIMIT = 150000;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start_i;
   logic [CNT_W-1:0]  periods_i;
   logic              adc_dout_i;
   logic              adc_conv_o;
   logic              adc_sclk_o;
   logic [DATA_W-1:0] result_o;
   logic              result_valid_o;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   sadc_frame_ctrl #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_PERIODS(MIN_N),
      .ACQ_PERIODS(ACQ), .DIV_HALF(DIV)
   ) i_sadc_frame_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .periods_i(periods_i),
      .adc_dout_i(adc_dout_i), .adc_conv_o(adc_conv_o), .adc_sclk_o(adc_sclk_o),
      .result_o(result_o), .result_valid_o(result_valid_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int clamp_n(input int p);
      return (p < MIN_N) ? MIN_N : p;
   endfunction

   // converter model and monitor state
   int   n_cur = MIN_N;
   logic [DATA_W-1:0] word_cur = '0;
   int   bitk = 0, rises = 0, low_len = 0, high_len = 0, since_fall = 0;
   bit   pd = 0, first_seen = 0, exact_next = 0;
   bit   prev_conv = 1, prev_sclk = 0, prev_valid = 0;
   logic [DATA_W-1:0] last_result = '0;
   int   frames_done = 0;
   bit   force_en = 0;
   logic [DATA_W-1:0] force_w = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!adc_conv_o && prev_conv) begin
            if (first_seen) chk(rises == n_cur, "R3 rising edges per frame (R10 no extra)", rises, n_cur);
            chk(high_len >= ACQ_CYC, "R8 acquisition time", high_len, ACQ_CYC);
            if (exact_next) chk(high_len == ACQ_CYC, "R9 back-to-back high time", high_len, ACQ_CYC);
            chk(!adc_sclk_o, "R2 strobe falls with bit clock low", adc_sclk_o, 0);
            exact_next = 0;
            n_cur      = clamp_n(int'(periods_i));
            word_cur   = force_en ? force_w : DATA_W'($urandom);
            force_en   = 0;
            bitk = 0; rises = 0; low_len = 0; high_len = 0; since_fall = 0; pd = 0;
            first_seen = 1;
            adc_dout_i = 1'b0;
         end else begin
            since_fall++;
         end
         if (adc_sclk_o && !prev_sclk) begin
            rises++;
            if (rises == 1) chk(since_fall == DIV, "R2 first edge delay", since_fall, DIV);
            if (rises == 13) pd = !adc_conv_o;
         end
         if (!adc_sclk_o && prev_sclk) begin
            bitk++;
            adc_dout_i = (bitk <= DATA_W) ? word_cur[DATA_W - bitk] : 1'b0;
         end
         if (adc_conv_o && !prev_conv) begin
            chk(low_len == (2 * (n_cur - ACQ) + 1) * DIV, "R4 strobe low length",
                low_len, (2 * (n_cur - ACQ) + 1) * DIV);
            chk(rises == n_cur - ACQ + 1, "R4 strobe rise edge", rises, n_cur - ACQ + 1);
            chk(pd == (n_cur > MIN_N), "R5 power-down entry", pd, int'(n_cur > MIN_N));
         end
         if (!adc_conv_o) low_len++;
         else             high_len++;
         if (result_valid_o) begin
            chk(!prev_valid, "R7 single-cycle valid", prev_valid, 0);
            chk(result_o == word_cur, "R6 captured word", result_o, word_cur);
            frames_done++;
         end else begin
            if (result_o != last_result) chk(0, "R7 result changed without valid", result_o, last_result);
         end
         last_result = result_o;
         prev_conv  = adc_conv_o;
         prev_sclk  = adc_sclk_o;
         prev_valid = result_valid_o;
      end
   end

   task automatic finish_up();
      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic run_frame(input int p, input bit fw_en, input logic [DATA_W-1:0] fw,
                            input bit b2b, input int p2);
      int target;
      target = frames_done + (b2b ? 2 : 1);
      @(negedge clk); #1;
      periods_i = CNT_W'(p);
      force_en  = fw_en;
      force_w   = fw;
      start_i   = 1'b1;
      @(negedge clk); #1;
      start_i = 1'b0;
      while (adc_conv_o) @(negedge clk);
      if (b2b) begin
         while (!adc_conv_o) @(negedge clk);
         #1;
         periods_i  = CNT_W'(p2);
         exact_next = 1;
         start_i    = 1'b1;
         @(negedge clk); #1;
         start_i = 1'b0;
      end
      while (frames_done < target) @(negedge clk);
      while (!adc_conv_o) @(negedge clk);
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      fails++;
      $display("FAIL watchdog R3: actual %0d expected %0d", frames_done, -1);
      finish_up();
   end

   initial begin
      int r0;
      r0 = $urandom(32'd2024);
      rst_n = 1'b0; start_i = 1'b0; periods_i = CNT_W'(MIN_N); adc_dout_i = 1'b0;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(adc_conv_o == 1'b1, "R1 strobe high in reset", adc_conv_o, 1);
      chk(adc_sclk_o == 1'b0, "R1 bit clock low in reset", adc_sclk_o, 0);
      chk(result_valid_o == 1'b0, "R1 valid low in reset", result_valid_o, 0);
      chk(result_o == '0, "R1 result zero in reset", result_o, 0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(adc_conv_o == 1'b1 && adc_sclk_o == 1'b0, "R1 state after reset", adc_sclk_o, 0);

      // directed corners: words at extremes, lengths around the minimum
      run_frame(16, 1, 12'hFFF, 0, 0);
      run_frame(5,  1, 12'h000, 0, 0);   // R3 clamp to 16
      run_frame(17, 1, 12'h800, 0, 0);   // R5 shortest power-down frame
      run_frame(0,  1, 12'h001, 0, 0);
      run_frame(255, 1, 12'hA5A, 0, 0);
      run_frame(16, 0, '0, 1, 30);       // R9 back-to-back
      run_frame(40, 0, '0, 1, 16);
      run_frame(3,  0, '0, 1, 3);

      for (int i = 0; i < 40; i++) begin
         int p, p2, gap;
         bit b;
         p   = int'($urandom % 48);
         p2  = int'($urandom % 48);
         b   = ($urandom % 3) == 0;
         gap = int'($urandom % 20);
         repeat (gap) @(negedge clk);
         run_frame(p, 0, '0, b, p2);
      end

      // R10 idle: no edges while nothing is requested
      begin
         int r_before;
         repeat (40) @(negedge clk);
         r_before = rises;
         repeat (200) @(negedge clk);
         chk(rises == r_before, "R10 no bit-clock edges when idle", rises, r_before);
         chk(adc_conv_o == 1'b1 && adc_sclk_o == 1'b0, "R10 idle levels", adc_sclk_o, 0);
      end
      finish_up();
   end
endmodule